// File: doc/BRIEF.md
# Slave-Mode Up/Down Counter Controller

This block is a general-purpose up/down counter whose clock and enable come from one of eight selectable slave behaviours rather than only from the system clock. An external parent trigger, picked from a small set of trigger inputs, can reload, gate, start or clock the counter. Two quadrature channel inputs can drive it as a position counter. When it wraps past its limit, the counter raises a single-cycle update event.

Software sets up the block through a plain register port with four word addresses: control, slave setup, preset and counter. The register port has no handshake and no back-pressure. A write is taken on every clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. No streaming data passes through the block, so it has no valid/ready interface. The trigger and channel inputs are asynchronous and are synchronised inside the block.

Top module: `slave_cnt_ctrl`

## Requirements
- R1: After reset, the control and slave registers read 0, the counter reads 0, the preset reads all ones and `upd_evt` is low.
- R2: Register addresses and fields:
  - Address 0 is control: bit 0 enables counting, bit 4 selects down counting (1) or up counting (0), and bit 7 turns on preset preloading. Its other bits read 0.
  - Address 1 is slave setup: bits [2:0] hold the mode and bits [6:4] hold the trigger index. Its other bits read 0.
  - Address 2 is the preset.
  - Address 3 is the counter. A write to address 3 loads the counter and takes priority over counting.
- R3: In mode 0 (internal clock), an enabled counter steps once per clock in the direction given by the direction bit. A disabled counter holds its value in every mode.
- R4: An up step taken at the active preset value wraps the counter to 0. A down step taken at 0 wraps it to the active preset value. Each wrap drives `upd_evt` high for exactly the one clock after the wrapping edge.
- R5: With preloading off, a preset write becomes the active limit at once. With preloading on, the written value is read back at once but becomes the active limit only at the next wrap.
- R6: Modes 1 to 3 are quadrature encoder modes, and the direction bit is ignored in them.
  - Mode 1 counts on channel B edges. It counts up when B equals A after the edge.
  - Mode 2 counts on channel A edges. It counts up when A differs from B after the edge.
  - Mode 3 counts on edges of both channels. If both channels change at once, nothing is counted.
  - Net effect: a full A-leads-B cycle adds 4 in mode 3 and 2 in modes 1 and 2, and the reverse cycle subtracts the same amounts.
- R7: Mode 4 (reset) counts like mode 0. A rising edge on the selected trigger reloads the counter to 0 when counting up, or to the active preset when counting down, with no step and no event on that edge.
- R8: Mode 5 (gated) steps the counter once per clock while the selected trigger is high. When the trigger goes low, the counter holds its value and is not cleared.
- R9: In mode 6 (trigger start), a rising edge on the selected trigger sets the enable bit without changing the counter. Counting on the internal clock begins on the following clock.
- R10: In mode 7 (trigger clock), each rising edge of the selected trigger steps the enabled counter exactly once.
- R11: Only the trigger input named by the trigger index has any effect. An index of `NTRIG` or above selects no trigger, which then reads as constant low.
- R12: Trigger and channel inputs pass through two synchronising flip-flops. A change on an input first affects the counter at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Combinational register read data |
| trig_in | input | NTRIG | Asynchronous parent trigger inputs |
| enc_a | input | 1 | Asynchronous quadrature channel A |
| enc_b | input | 1 | Asynchronous quadrature channel B |
| upd_evt | output | 1 | One-cycle wrap event pulse |

## Verification
Results are due at these edges:
- A register write takes effect on the edge that samples it.
- A newly set enable first steps the counter one edge later.
- A trigger or channel change applied between edges first acts on the counter at the third following edge.
- A wrap shows on `upd_evt` during the clock after the wrapping edge.

The bench drives every input on the falling edge. It advances by a counted number of rising edges and reads the counter on the next falling edge, so each expected value is the start value moved by exactly the number of steps those edges allow. Trigger pulses are held well beyond the synchroniser latency and the readout waits out that latency, with one check made deliberately one edge early to pin the latency itself.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [2:0] {
    MODE_INT    = 3'd0,
    MODE_ENC_B  = 3'd1,
    MODE_ENC_A  = 3'd2,
    MODE_ENC_AB = 3'd3,
    MODE_RELOAD = 3'd4,
    MODE_GATE   = 3'd5,
    MODE_START  = 3'd6,
    MODE_EXTCLK = 3'd7
  } scc_mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_SLAVE  = 2'd1;
  localparam logic [1:0] ADDR_PRESET = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  localparam int BIT_CEN     = 0;
  localparam int BIT_DIR     = 4;
  localparam int BIT_PRELOAD = 7;
  localparam int MODE_LSB    = 0;
  localparam int SEL_LSB     = 4;
  localparam int SEL_W       = 3;
  localparam int SEL_SLOTS   = 1 << SEL_W;

endpackage

// File: rtl/scc_in_sync.sv
module scc_in_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] tog
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], async_in[g]};
    end
    assign lvl[g] = sh[1];
    assign tog[g] = sh[1] ^ sh[2];
  end
endmodule

// File: rtl/scc_step_dec.sv
module scc_step_dec
  import scc_pkg::*;
(
  input  scc_mode_e mode,
  input  logic      cen,
  input  logic      dir,
  input  logic      trig_lvl,
  input  logic      trig_rise,
  input  logic      a_lvl,
  input  logic      b_lvl,
  input  logic      a_tog,
  input  logic      b_tog,
  output logic      step,
  output logic      step_dn,
  output logic      reload,
  output logic      start
);
  logic a_only, b_only;
  assign a_only = a_tog & ~b_tog;
  assign b_only = b_tog & ~a_tog;

  always_comb begin
    step    = 1'b0;
    step_dn = dir;
    reload  = 1'b0;
    start   = 1'b0;
    case (mode)
      MODE_INT:    step = cen;
      MODE_ENC_B: begin
        step    = cen & b_only;
        step_dn = a_lvl ^ b_lvl;
      end
      MODE_ENC_A: begin
        step    = cen & a_only;
        step_dn = ~(a_lvl ^ b_lvl);
      end
      MODE_ENC_AB: begin
        step    = cen & (a_only | b_only);
        step_dn = a_only ? ~(a_lvl ^ b_lvl) : (a_lvl ^ b_lvl);
      end
      MODE_RELOAD: begin
        reload = cen & trig_rise;
        step   = cen & ~trig_rise;
      end
      MODE_GATE:   step = cen & trig_lvl;
      MODE_START: begin
        step  = cen;
        start = ~cen & trig_rise;
      end
      MODE_EXTCLK: step = cen & trig_rise;
      default:     step = 1'b0;
    endcase
  end
endmodule

// File: rtl/scc_count_core.sv
module scc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_dn,
  input  logic             reload,
  input  logic             reload_dn,
  input  logic             cnt_wr,
  input  logic             preset_wr,
  input  logic             preload,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] preset_buf,
  output logic [CNT_W-1:0] preset_act,
  output logic             upd_evt
);
  logic [CNT_W-1:0] wrap_val;
  logic             wrap_now;

  // value the active limit takes if a wrap happens on this edge
  assign wrap_val = preload ? preset_buf : (preset_wr ? wr_data : preset_act);
  assign wrap_now = !cnt_wr && !reload && step &&
                    (step_dn ? (cnt == '0) : (cnt == preset_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      preset_buf <= '1;
      preset_act <= '1;
      upd_evt    <= 1'b0;
    end else begin
      upd_evt <= wrap_now;
      if (preset_wr) preset_buf <= wr_data;
      if (wrap_now)                    preset_act <= wrap_val;
      else if (preset_wr && !preload)  preset_act <= wr_data;
      if (cnt_wr)                      cnt <= wr_data;
      else if (reload)                 cnt <= reload_dn ? preset_act : '0;
      else if (wrap_now)               cnt <= step_dn ? wrap_val : '0;
      else if (step)                   cnt <= step_dn ? cnt - 1'b1 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/slave_cnt_ctrl.sv
module slave_cnt_ctrl
  import scc_pkg::*;
#(
  parameter int CNT_W = 16,  // at least 8
  parameter int NTRIG = 5    // at most 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic             upd_evt
);
  logic             cen_q, dir_q, preload_q;
  scc_mode_e        mode_q;
  logic [SEL_W-1:0] sel_q;

  logic [NTRIG-1:0]     t_lvl, t_tog;
  logic [SEL_SLOTS-1:0] lvl_pad, tog_pad;
  logic [1:0]           e_lvl, e_tog;
  logic                 trig_lvl, trig_rise;
  logic                 step, step_dn, reload, start;
  logic                 cnt_wr, preset_wr;
  logic [CNT_W-1:0]     cnt_q, preset_buf, preset_act;

  scc_in_sync #(.W(NTRIG)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .lvl(t_lvl), .tog(t_tog));

  scc_in_sync #(.W(2)) u_enc_sync (
    .clk(clk), .rst_n(rst_n), .async_in({enc_b, enc_a}), .lvl(e_lvl), .tog(e_tog));

  always_comb begin
    lvl_pad = '0;
    tog_pad = '0;
    lvl_pad[NTRIG-1:0] = t_lvl;
    tog_pad[NTRIG-1:0] = t_tog;
  end
  assign trig_lvl  = lvl_pad[sel_q];
  assign trig_rise = lvl_pad[sel_q] & tog_pad[sel_q];

  assign cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);
  assign preset_wr = wr_en && (wr_addr == ADDR_PRESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q     <= 1'b0;
      dir_q     <= 1'b0;
      preload_q <= 1'b0;
      mode_q    <= MODE_INT;
      sel_q     <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL) begin
        cen_q     <= wr_data[BIT_CEN];
        dir_q     <= wr_data[BIT_DIR];
        preload_q <= wr_data[BIT_PRELOAD];
      end else if (start) begin
        cen_q <= 1'b1;
      end
      if (wr_en && wr_addr == ADDR_SLAVE) begin
        mode_q <= scc_mode_e'(wr_data[MODE_LSB +: 3]);
        sel_q  <= wr_data[SEL_LSB +: SEL_W];
      end
    end
  end

  scc_step_dec u_dec (
    .mode(mode_q), .cen(cen_q), .dir(dir_q),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise),
    .a_lvl(e_lvl[0]), .b_lvl(e_lvl[1]), .a_tog(e_tog[0]), .b_tog(e_tog[1]),
    .step(step), .step_dn(step_dn), .reload(reload), .start(start));

  scc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .step(step), .step_dn(step_dn), .reload(reload), .reload_dn(dir_q),
    .cnt_wr(cnt_wr), .preset_wr(preset_wr), .preload(preload_q),
    .wr_data(wr_data), .cnt(cnt_q), .preset_buf(preset_buf),
    .preset_act(preset_act), .upd_evt(upd_evt));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[BIT_CEN]     = cen_q;
        rd_data[BIT_DIR]     = dir_q;
        rd_data[BIT_PRELOAD] = preload_q;
      end
      ADDR_SLAVE: begin
        rd_data[MODE_LSB +: 3]   = mode_q;
        rd_data[SEL_LSB +: SEL_W] = sel_q;
      end
      ADDR_PRESET: rd_data = preset_buf;
      default:     rd_data = cnt_q;
    endcase
  end
endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             cen,
  input logic             cnt_wr,
  input logic             trig_lvl,
  input logic             trig_rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset_act,
  input logic             upd_evt
);
  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !cnt_wr) |=> (cnt == $past(cnt)));

  // R8
  gate_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !trig_lvl && !cnt_wr) |=> (cnt == $past(cnt)));

  // R10
  extclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && !trig_rise && !cnt_wr) |=> (cnt == $past(cnt)));

  // R4
  evt_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> (cnt == '0 || cnt == preset_act));
endmodule

bind slave_cnt_ctrl scc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .cen(cen_q), .cnt_wr(cnt_wr),
  .trig_lvl(trig_lvl), .trig_rise(trig_rise), .cnt(cnt_q),
  .preset_act(preset_act), .upd_evt(upd_evt));

// File: tb/slave_cnt_ctrl_tb_top.sv
module slave_cnt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [NT-1:0] trig_in = '0;
  logic          enc_a = 1'b0, enc_b = 1'b0;
  logic          upd_evt;

  int n_chk = 0, n_fail = 0, evt_total = 0;

  slave_cnt_ctrl #(.CNT_W(CW), .NTRIG(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig_in(trig_in), .enc_a(enc_a), .enc_b(enc_b), .upd_evt(upd_evt));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (upd_evt === 1'b1) evt_total++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  function automatic int up_after(int s, int p, int k);
    return (s + k) % (p + 1);
  endfunction
  function automatic int dn_after(int s, int p, int k);
    return (((s - k) % (p + 1)) + (p + 1)) % (p + 1);
  endfunction
  function automatic int wraps(int s, int p, int k, bit dn);
    int n = 0;
    for (int j = 0; j < k; j++)
      if (dn ? (dn_after(s, p, j) == 0) : (up_after(s, p, j) == p)) n++;
    return n;
  endfunction

  task automatic enc_cycle(input bit rev);
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: if (rev) enc_b = 1'b1; else enc_a = 1'b1;
        1: if (rev) enc_a = 1'b1; else enc_b = 1'b1;
        2: if (rev) enc_b = 1'b0; else enc_a = 1'b0;
        default: if (rev) enc_a = 1'b0; else enc_b = 1'b0;
      endcase
      cycles(4);
    end
  endtask

  task automatic pulse(input int idx);
    trig_in[idx] = 1'b1; cycles(3);
    trig_in[idx] = 1'b0; cycles(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, e0, c0, n;
    void'($urandom(32'd1357));
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 slave", v, 0);
    rd(2, v); check("R1 preset", v, 16'hFFFF);
    rd(3, v); check("R1 count", v, 0);
    check("R1 evt", int'(upd_evt), 0);

    // R2 field layout
    wr(0, 16'hFFFF); rd(0, v); check("R2 ctrl fields", v, 16'h0091);
    wr(0, 0);
    wr(1, 16'hFFFF); rd(1, v); check("R2 slave fields", v, 16'h0077);
    wr(1, 0);

    // R3/R4 internal clock up
    wr(2, 5); wr(3, 0); e0 = evt_total;
    wr(0, 1); cycles(14);
    rd(3, v); check("R3 up count", v, up_after(0, 5, 14));
    check("R4 up events", evt_total - e0, wraps(0, 5, 14, 0));
    wr(0, 0); rd(3, c0); cycles(7); rd(3, v);
    check("R3 disabled hold", v, c0);

    // R3/R4 down
    wr(3, 3); wr(2, 4); e0 = evt_total;
    wr(0, 16'h11); cycles(11);
    rd(3, v); check("R3 down count", v, dn_after(3, 4, 11));
    check("R4 down events", evt_total - e0, wraps(3, 4, 11, 1));
    wr(0, 0);

    // R3/R4 random runs in internal mode
    for (int it = 0; it < 16; it++) begin
      int p, s, k; bit d;
      p = 2 + int'($urandom % 15); s = int'($urandom % (p + 1));
      d = 1'($urandom % 2); k = int'($urandom % 40);
      wr(0, 0); wr(2, p); wr(3, s); e0 = evt_total;
      wr(0, d ? 16'h11 : 16'h01); cycles(k); wr(0, 0);
      rd(3, v);
      check("R3 random count", v, d ? dn_after(s, p, k + 1) : up_after(s, p, k + 1));
      check("R4 random events", evt_total - e0, wraps(s, p, k + 1, d));
    end

    // R5 preload on
    wr(2, 9); wr(3, 0); wr(0, 16'h81); cycles(2);
    wr(2, 3); rd(2, v); check("R5 preset readback", v, 3);
    cycles(4); rd(3, v); check("R5 old limit held", v, 7);
    cycles(3); rd(3, v); check("R5 wrap at old limit", v, 0);
    cycles(5); rd(3, v); check("R5 new limit after wrap", v, 1);
    // R5 preload off
    wr(0, 0); wr(2, 9); wr(3, 0); wr(0, 1); cycles(1);
    wr(2, 4); cycles(3); rd(3, v); check("R5 immediate limit", v, 0);
    wr(0, 0);

    // R7/R12 reset mode, trigger 2
    wr(2, 50); wr(3, 20); wr(1, (2 << 4) | 4); wr(0, 1);
    cycles(3);
    trig_in[2] = 1'b1; cycles(2);
    rd(3, v); check("R12 not yet synced", v, 25);
    cycles(1); rd(3, v); check("R7 reload up", v, 0);
    cycles(4); rd(3, v); check("R7 counts after reload", v, 4);
    trig_in[2] = 1'b0; cycles(3);
    wr(0, 16'h11); cycles(2);
    trig_in[2] = 1'b1; cycles(3);
    rd(3, v); check("R7 reload down", v, 50);
    trig_in[2] = 1'b0; wr(0, 0);

    // R8 gated, trigger 0
    wr(2, 1000); wr(3, 10); wr(1, 5); wr(0, 1);
    cycles(6); rd(3, v); check("R8 gate low", v, 10);
    trig_in[0] = 1'b1; cycles(7);
    trig_in[0] = 1'b0; cycles(8);
    rd(3, v); check("R8 held not cleared", v, 17);
    wr(0, 0);

    // R9 trigger start, trigger 1
    wr(3, 5); wr(1, (1 << 4) | 6);
    cycles(5); rd(3, v); check("R9 waits for trigger", v, 5);
    trig_in[1] = 1'b1; cycles(3);
    rd(3, v); check("R9 start keeps value", v, 5);
    rd(0, v); check("R9 enable set", v & 1, 1);
    cycles(4); rd(3, v); check("R9 counting", v, 9);
    trig_in[1] = 1'b0; wr(0, 0);

    // R10/R11 trigger clock
    wr(3, 0); wr(1, (3 << 4) | 7); wr(0, 1);
    n = 3 + int'($urandom % 6);
    for (int i = 0; i < n; i++) pulse(3);
    cycles(3); rd(3, v); check("R10 edge count", v, n);
    pulse(4); pulse(4); pulse(0);
    rd(3, v); check("R11 other trigger ignored", v, n);
    wr(1, (5 << 4) | 7);
    trig_in = '1; cycles(4); trig_in = '0; cycles(4);
    rd(3, v); check("R11 index out of range", v, n);
    wr(1, (4 << 4) | 7); pulse(4); cycles(2);
    rd(3, v); check("R11 index 4 selected", v, n + 1);
    wr(0, 0);

    // R6 encoder modes
    wr(3, 100); wr(1, 3); wr(0, 1);
    enc_cycle(0); cycles(3); rd(3, v); check("R6 mode3 forward", v, 104);
    enc_cycle(1); enc_cycle(1); cycles(3); rd(3, v); check("R6 mode3 reverse", v, 96);
    wr(1, 1); enc_cycle(0); cycles(3); rd(3, v); check("R6 mode1 forward", v, 98);
    wr(1, 2); enc_cycle(1); cycles(3); rd(3, v); check("R6 mode2 reverse", v, 96);
    wr(1, 3); wr(0, 16'h11); enc_cycle(0); cycles(3);
    rd(3, v); check("R6 direction bit ignored", v, 100);
    wr(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule